// File: doc/BRIEF.md
# Instruction Cache Miss Prefetcher

This sequencer sits between an instruction cache and the read request port of a system bus. A miss is accepted only while the fetch buffers are filling. It then requests the missed line and up to three following sequential lines. A following line is skipped when the cache reports it already present, and the burst stops at the end of a 4 KB page. Requests go out back to back, so several lines are in flight before the first data returns. At most eight lines may be outstanding at once.

The bus returns each 32-byte line as four 8-byte beats, in the order the lines were requested. Every beat is written into the cache one cycle after it arrives. Beats of the missed line are also forwarded to the fetch path as they arrive. A branch redirect or flush drops the lines not yet requested, and data for lines already in flight is still written.

The control is a three-state machine:
- `ST_IDLE` waits for a miss.
- `ST_DEMAND` requests the missed line.
- `ST_AHEAD` probes and requests the following lines.

It has four transitions:
- ARM (`ST_IDLE` to `ST_DEMAND`) on an accepted miss.
- ADVANCE (`ST_DEMAND` or `ST_AHEAD` to `ST_AHEAD`) after a line is requested or skipped and more lines remain.
- FINISH (to `ST_IDLE`) after the fourth line or the last line of a page.
- CANCEL (to `ST_IDLE`) on a redirect.

Top module: `ifp_prefetch_seq`

## Requirements
- R1: A miss is taken only in `ST_IDLE` with `fetch_filling` high and `redirect` low. Any other miss is ignored: no request is made and `busy` stays low.
- R2: The first request of a burst is always made, without a probe, at byte address `miss_line * 32`.
- R3: A burst covers at most four consecutive lines, each line address 32 above the previous one.
- R4: No line beyond the last 32-byte line of the 4 KB page holding the missed line is requested.
- R5: A following line is probed via `probe_addr`. When `probe_hit` is high it is skipped without a request, and the burst continues with the next line.
- R6: Requests of a burst go out on consecutive cycles while `breq_grant` is high, without waiting for data. No request is presented while eight lines are outstanding. Issue resumes once a line completes.
- R7: Every returned beat is written, one cycle after it arrives, with `cwr_en` high. The write address is the requested line address plus 8 times the beat's index (0 to 3, in arrival order). The write data is the beat. Lines are matched to requests in issue order.
- R8: Each beat of a burst's missed line is also given out with `fwd_valid` high, carrying the same data, in the same cycle as its cache write. Beats of following lines are not forwarded.
- R9: `redirect` cancels every line of the current burst not yet requested. A request is never presented in the cycle after a redirect. Lines already requested are still written in full.
- R10: During and right after reset, `breq_valid`, `cwr_en`, `fwd_valid` and `busy` are low.
- R11: `busy` is high while a burst is being issued or any requested line has not fully returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| fetch_filling | input | 1 | fetch buffers are being filled |
| miss_valid | input | 1 | instruction cache miss |
| miss_line | input | 27 | line address of the miss (byte address / 32) |
| redirect | input | 1 | branch redirect or flush |
| probe_addr | output | 32 | byte address of the line being considered |
| probe_hit | input | 1 | cache holds the line at `probe_addr` |
| breq_valid | output | 1 | line read request |
| breq_addr | output | 32 | byte address of requested line |
| breq_grant | input | 1 | bus accepts the request this cycle |
| bdat_valid | input | 1 | returning data beat |
| bdat_data | input | 64 | beat data |
| cwr_en | output | 1 | cache fill write |
| cwr_addr | output | 32 | byte address of the written beat |
| cwr_data | output | 64 | written data |
| fwd_valid | output | 1 | missed-line beat forwarded to fetch |
| fwd_data | output | 64 | forwarded data |
| busy | output | 1 | burst active or lines outstanding |

## Verification
Completion of a line (the fourth beat removes a tracker entry) can fall in the same cycle as the grant of a new request (which adds an entry). A bench bus model returns data while bursts are still issuing. It also stalls returns until eight lines are outstanding and then releases them with a third burst waiting, so pushes and pops coincide near the limit. It is judged by a bench count of outstanding lines that must never allow a request at eight, and by every write landing on the address of the matching request in issue order. A redirect in the same cycle as a presented request is also provoked, and exactly the earlier request must be written.

// File: rtl/ifp_pkg.sv
package ifp_pkg;

    // burst sequencer states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DEMAND = 2'd1,
        ST_AHEAD  = 2'd2
    } ifp_state_e;

endpackage

// File: rtl/ifp_track_fifo.sv
// In-order tracker of requested lines awaiting data.
module ifp_track_fifo #(
    parameter int W     = 28,
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head_data,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + PTR_W'(1);
            if (pop)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + PTR_W'(1);
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_data = mem[rd_q];
    assign count     = cnt_q;

endmodule

// File: rtl/ifp_issue_fsm.sv
// Burst issue sequencer: demand line, then probed follow-on lines.
module ifp_issue_fsm
    import ifp_pkg::*;
#(
    parameter int LADDR_W     = 27,
    parameter int PAGE_LINE_W = 7,
    parameter int BURST_LINES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_filling,
    input  logic               miss_valid,
    input  logic [LADDR_W-1:0] miss_line,
    input  logic               redirect,
    input  logic               probe_hit,
    input  logic               breq_grant,
    input  logic               slot_free,
    output logic [LADDR_W-1:0] cur_line,
    output logic               req_valid,
    output logic               req_demand,
    output logic               active
);
    localparam int IDX_W = $clog2(BURST_LINES + 1);

    ifp_state_e         state_q, state_d;
    logic [LADDR_W-1:0] line_q, line_d;
    logic [IDX_W-1:0]   idx_q, idx_d;
    logic               step;
    logic               last_in_burst;
    logic               last_in_page;

    assign last_in_burst = (idx_q == IDX_W'(BURST_LINES - 1));
    assign last_in_page  = &line_q[PAGE_LINE_W-1:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            line_q  <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            line_q  <= line_d;
            idx_q   <= idx_d;
        end
    end

    // next state: ARM, ADVANCE, FINISH, CANCEL
    always_comb begin
        state_d = state_q;
        line_d  = line_q;
        idx_d   = idx_q;
        step    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (miss_valid && fetch_filling && !redirect) begin
                    state_d = ST_DEMAND;
                    line_d  = miss_line;
                    idx_d   = '0;
                end
            end
            ST_DEMAND: begin
                if (redirect)                    state_d = ST_IDLE;
                else if (slot_free && breq_grant) step   = 1'b1;
            end
            ST_AHEAD: begin
                if (redirect)                    state_d = ST_IDLE;
                else if (probe_hit)              step    = 1'b1;
                else if (slot_free && breq_grant) step   = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
        if (step) begin
            if (last_in_burst || last_in_page) begin
                state_d = ST_IDLE;
            end else begin
                state_d = ST_AHEAD;
                line_d  = line_q + LADDR_W'(1);
                idx_d   = idx_q + IDX_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        req_valid  = 1'b0;
        req_demand = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_valid = 1'b0;
            ST_DEMAND: begin
                req_valid  = slot_free && !redirect;
                req_demand = 1'b1;
            end
            ST_AHEAD:  req_valid = slot_free && !redirect && !probe_hit;
            default:   req_valid = 1'b0;
        endcase
    end

    assign cur_line = line_q;
    assign active   = (state_q != ST_IDLE);

endmodule

// File: rtl/ifp_beat_writer.sv
// Counts beats of the head line, writes them to the cache and forwards demand beats.
module ifp_beat_writer #(
    parameter int LADDR_W = 27,
    parameter int BEATS   = 4,
    parameter int BEAT_W  = 2,
    parameter int BEAT_LG = 3,
    parameter int DATA_W  = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bdat_valid,
    input  logic [DATA_W-1:0]                 bdat_data,
    input  logic                              head_ok,
    input  logic [LADDR_W-1:0]                head_line,
    input  logic                              head_demand,
    output logic                              line_done,
    output logic                              cwr_en,
    output logic [LADDR_W+BEAT_W+BEAT_LG-1:0] cwr_addr,
    output logic [DATA_W-1:0]                 cwr_data,
    output logic                              fwd_valid
);
    logic [BEAT_W-1:0]                 beat_q;
    logic                              take;
    logic                              last_beat;
    logic                              en_q, fwd_q;
    logic [LADDR_W+BEAT_W+BEAT_LG-1:0] addr_q;
    logic [DATA_W-1:0]                 data_q;

    assign take      = bdat_valid && head_ok;
    assign last_beat = (beat_q == BEAT_W'(BEATS - 1));
    assign line_done = take && last_beat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
            en_q   <= 1'b0;
            fwd_q  <= 1'b0;
        end else begin
            en_q  <= take;
            fwd_q <= take && head_demand;
            if (take) beat_q <= last_beat ? '0 : beat_q + BEAT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            addr_q <= {head_line, beat_q, {BEAT_LG{1'b0}}};
            data_q <= bdat_data;
        end
    end

    assign cwr_en    = en_q;
    assign cwr_addr  = addr_q;
    assign cwr_data  = data_q;
    assign fwd_valid = fwd_q;

endmodule

// File: rtl/ifp_prefetch_seq.sv
// Instruction cache miss prefetcher: top level.
module ifp_prefetch_seq #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int BEAT_BYTES  = 8,
    parameter int BURST_LINES = 4,
    parameter int MAX_OUTST   = 8,
    parameter int PAGE_BYTES  = 4096
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 fetch_filling,
    input  logic                                 miss_valid,
    input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0] miss_line,
    input  logic                                 redirect,
    output logic [ADDR_W-1:0]                    probe_addr,
    input  logic                                 probe_hit,
    output logic                                 breq_valid,
    output logic [ADDR_W-1:0]                    breq_addr,
    input  logic                                 breq_grant,
    input  logic                                 bdat_valid,
    input  logic [8*BEAT_BYTES-1:0]              bdat_data,
    output logic                                 cwr_en,
    output logic [ADDR_W-1:0]                    cwr_addr,
    output logic [8*BEAT_BYTES-1:0]              cwr_data,
    output logic                                 fwd_valid,
    output logic [8*BEAT_BYTES-1:0]              fwd_data,
    output logic                                 busy
);
    localparam int LINE_LG     = $clog2(LINE_BYTES);
    localparam int BEAT_LG     = $clog2(BEAT_BYTES);
    localparam int BEATS       = LINE_BYTES / BEAT_BYTES;
    localparam int BEAT_W      = $clog2(BEATS);
    localparam int LADDR_W     = ADDR_W - LINE_LG;
    localparam int PAGE_LINE_W = $clog2(PAGE_BYTES) - LINE_LG;
    localparam int DATA_W      = 8 * BEAT_BYTES;
    localparam int CNT_W       = $clog2(MAX_OUTST + 1);

    logic [LADDR_W-1:0] cur_line;
    logic               fsm_valid, fsm_demand, fsm_active;
    logic               slot_free, push, pop;
    logic [CNT_W-1:0]   trk_count;
    logic [LADDR_W:0]   head_entry;

    assign slot_free = (trk_count < CNT_W'(MAX_OUTST));

    ifp_issue_fsm #(
        .LADDR_W    (LADDR_W),
        .PAGE_LINE_W(PAGE_LINE_W),
        .BURST_LINES(BURST_LINES)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_filling(fetch_filling),
        .miss_valid   (miss_valid),
        .miss_line    (miss_line),
        .redirect     (redirect),
        .probe_hit    (probe_hit),
        .breq_grant   (breq_grant),
        .slot_free    (slot_free),
        .cur_line     (cur_line),
        .req_valid    (fsm_valid),
        .req_demand   (fsm_demand),
        .active       (fsm_active)
    );

    assign push = fsm_valid && breq_grant;

    ifp_track_fifo #(
        .W    (LADDR_W + 1),
        .DEPTH(MAX_OUTST),
        .CNT_W(CNT_W)
    ) trk_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_data({fsm_demand, cur_line}),
        .pop      (pop),
        .head_data(head_entry),
        .count    (trk_count)
    );

    ifp_beat_writer #(
        .LADDR_W(LADDR_W),
        .BEATS  (BEATS),
        .BEAT_W (BEAT_W),
        .BEAT_LG(BEAT_LG),
        .DATA_W (DATA_W)
    ) wr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bdat_valid (bdat_valid),
        .bdat_data  (bdat_data),
        .head_ok    (trk_count != '0),
        .head_line  (head_entry[LADDR_W-1:0]),
        .head_demand(head_entry[LADDR_W]),
        .line_done  (pop),
        .cwr_en     (cwr_en),
        .cwr_addr   (cwr_addr),
        .cwr_data   (cwr_data),
        .fwd_valid  (fwd_valid)
    );

    assign probe_addr = {cur_line, {LINE_LG{1'b0}}};
    assign breq_addr  = {cur_line, {LINE_LG{1'b0}}};
    assign breq_valid = fsm_valid;
    assign fwd_data   = cwr_data;
    assign busy       = fsm_active || (trk_count != '0);

endmodule

// File: rtl/ifp_chk.sv
// Protocol checker for the prefetch sequencer.
module ifp_chk #(
    parameter int MAX_OUTST   = 8,
    parameter int CNT_W       = 4,
    parameter int PAGE_LINE_W = 7
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   redirect,
    input logic                   breq_valid,
    input logic                   breq_grant,
    input logic                   req_demand,
    input logic [PAGE_LINE_W-1:0] page_line,
    input logic                   bdat_valid,
    input logic                   cwr_en,
    input logic                   fwd_valid,
    input logic [CNT_W-1:0]       trk_count
);
    // R6
    outst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_count == CNT_W'(MAX_OUTST)) |-> !breq_valid);

    // R6
    outst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trk_count <= CNT_W'(MAX_OUTST));

    // R9
    redirect_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !breq_valid);

    // R7
    write_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cwr_en |-> $past(bdat_valid));

    // R8
    fwd_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> cwr_en);

    // R4
    page_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (breq_valid && !req_demand && $past(breq_valid && breq_grant)) |-> (page_line != '0));

endmodule

bind ifp_prefetch_seq ifp_chk #(
    .MAX_OUTST  (MAX_OUTST),
    .CNT_W      (CNT_W),
    .PAGE_LINE_W(PAGE_LINE_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .redirect  (redirect),
    .breq_valid(breq_valid),
    .breq_grant(breq_grant),
    .req_demand(fsm_demand),
    .page_line (breq_addr[PAGE_LINE_W+LINE_LG-1:LINE_LG]),
    .bdat_valid(bdat_valid),
    .cwr_en    (cwr_en),
    .fwd_valid (fwd_valid),
    .trk_count (trk_count)
);

// File: tb/ifp_prefetch_seq_tb_top.sv
module ifp_prefetch_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_filling = 1'b1;
    logic        miss_valid = 1'b0;
    logic [26:0] miss_line = '0;
    logic        redirect = 1'b0;
    logic [31:0] probe_addr;
    logic        probe_hit;
    logic        breq_valid;
    logic [31:0] breq_addr;
    logic        breq_grant = 1'b1;
    logic        bdat_valid = 1'b0;
    logic [63:0] bdat_data = '0;
    logic        cwr_en;
    logic [31:0] cwr_addr;
    logic [63:0] cwr_data;
    logic        fwd_valid;
    logic [63:0] fwd_data;
    logic        busy;

    always #10 clk = ~clk;

    ifp_prefetch_seq dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_filling(fetch_filling),
        .miss_valid(miss_valid), .miss_line(miss_line), .redirect(redirect),
        .probe_addr(probe_addr), .probe_hit(probe_hit),
        .breq_valid(breq_valid), .breq_addr(breq_addr), .breq_grant(breq_grant),
        .bdat_valid(bdat_valid), .bdat_data(bdat_data),
        .cwr_en(cwr_en), .cwr_addr(cwr_addr), .cwr_data(cwr_data),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data), .busy(busy)
    );

    // scenario vectors: miss byte address, hit mask (bit k = line k present), expected request count
    localparam logic [31:0] VA [8] = '{32'h0000_1000, 32'h0000_2044, 32'h0000_1FC0, 32'h0000_1FE8,
                                       32'h0000_3000, 32'h0000_4000, 32'h0000_5FA0, 32'h1234_5678};
    localparam logic [3:0]  VM [8] = '{4'b0000, 4'b0000, 4'b0000, 4'b0000,
                                       4'b0110, 4'b1110, 4'b0100, 4'b0000};
    localparam int          VN [8] = '{4, 4, 2, 1, 2, 1, 2, 4};

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    function automatic logic [63:0] pat(input logic [31:0] a);
        return {a, ~a};
    endfunction

    // cache presence model for follow-on lines
    logic [31:0] tb_base = '0;
    logic [3:0]  tb_mask = '0;
    logic [31:0] diff;
    always_comb begin
        diff      = (probe_addr >> 5) - (tb_base >> 5);
        probe_hit = (diff >= 32'd1 && diff <= 32'd3) ? tb_mask[diff[1:0]] : 1'b0;
    end

    // bus model, request log, write and forward monitors
    logic [31:0] req_log [64];
    int          req_cyc [64];
    int          req_wr = 0, resp_rd = 0, resp_beat = 0;
    logic        resp_en = 1'b1;
    int          w_line = 0, w_beat = 0, n_wr = 0;
    logic [31:0] dq [16];
    int          dq_wr = 0, fd_line = 0, fd_beat = 0, n_fwd = 0;
    logic [31:0] wexp, fexp;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (cwr_en) begin
                wexp = req_log[w_line & 63] + 32'(w_beat * 8);
                chk(w_line < req_wr && cwr_addr == wexp, "R7", "write address", 64'(cwr_addr), 64'(wexp));
                chk(cwr_data == pat(wexp), "R7", "write data", cwr_data, pat(wexp));
                w_beat++;
                if (w_beat == 4) begin w_beat = 0; w_line++; end
                n_wr++;
            end
            if (fwd_valid) begin
                fexp = dq[fd_line & 15] + 32'(fd_beat * 8);
                chk(fwd_data == pat(fexp), "R8", "forward data", fwd_data, pat(fexp));
                fd_beat++;
                if (fd_beat == 4) begin fd_beat = 0; fd_line++; end
                n_fwd++;
            end
            if (breq_valid && (req_wr - resp_rd) >= 8)
                chk(1'b0, "R6", "request while eight outstanding", 64'(req_wr - resp_rd), 64'd7);
            if (resp_en && resp_rd < req_wr) begin
                bdat_valid <= 1'b1;
                bdat_data  <= pat(req_log[resp_rd & 63] + 32'(resp_beat * 8));
                resp_beat++;
                if (resp_beat == 4) begin resp_beat = 0; resp_rd++; end
            end else begin
                bdat_valid <= 1'b0;
            end
            if (breq_valid && breq_grant) begin
                req_log[req_wr & 63] = breq_addr;
                req_cyc[req_wr & 63] = cyc;
                req_wr++;
            end
        end
    end

    // watchdog
    always @(negedge clk) begin
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R11 watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic pulse_miss(input logic [31:0] a);
        @(posedge clk); #1;
        miss_valid = 1'b1;
        miss_line  = a[31:5];
        @(posedge clk); #1;
        miss_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        repeat (3) @(negedge clk);
    endtask

    logic [31:0] el [4];
    logic [31:0] lad;
    int          n, s, wr0, fw0;

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(!breq_valid, "R10", "breq_valid in reset", 64'(breq_valid), 64'd0);
        chk(!cwr_en,     "R10", "cwr_en in reset",     64'(cwr_en),     64'd0);
        chk(!fwd_valid,  "R10", "fwd_valid in reset",  64'(fwd_valid),  64'd0);
        chk(!busy,       "R10", "busy in reset",       64'(busy),       64'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !breq_valid, "R10", "idle after reset", 64'({busy, breq_valid}), 64'd0);

        // vector table: R2 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < 8; v++) begin
            s   = req_wr;
            wr0 = n_wr;
            fw0 = n_fwd;
            tb_base = VA[v];
            tb_mask = VM[v];
            dq[dq_wr & 15] = VA[v] & 32'hFFFF_FFE0;
            dq_wr++;
            pulse_miss(VA[v]);
            wait_idle();
            n = 0;
            for (int k = 0; k < 4; k++) begin
                lad = (VA[v] & 32'hFFFF_FFE0) + 32'(32 * k);
                if (k == 0 || !VM[v][k]) begin
                    el[n] = lad;
                    n++;
                end
                if (lad[11:0] == 12'hFE0) break;
            end
            chk(n == VN[v], "R4", "table count vs rule", 64'(n), 64'(VN[v]));
            chk(req_wr - s == VN[v], "R3", "requests in burst", 64'(req_wr - s), 64'(VN[v]));
            for (int k = 0; k < 4; k++) begin
                if (k < n && k < req_wr - s)
                    chk(req_log[(s + k) & 63] == el[k], (k == 0) ? "R2" : "R5",
                        "request address", 64'(req_log[(s + k) & 63]), 64'(el[k]));
            end
            if (VM[v] == 4'b0000 && n > 1 && req_wr - s == n)
                chk(req_cyc[(s + n - 1) & 63] - req_cyc[s & 63] == n - 1, "R6",
                    "back-to-back issue span", 64'(req_cyc[(s + n - 1) & 63] - req_cyc[s & 63]), 64'(n - 1));
            chk(n_wr - wr0 == 4 * VN[v], "R7", "writes in burst", 64'(n_wr - wr0), 64'(4 * VN[v]));
            chk(n_fwd - fw0 == 4, "R8", "forwarded beats", 64'(n_fwd - fw0), 64'd4);
        end
        tb_mask = '0;

        // R1: miss ignored outside fetch fill, and when redirect coincides
        s = req_wr;
        fetch_filling = 1'b0;
        pulse_miss(32'h0000_6000);
        repeat (4) @(negedge clk);
        chk(req_wr == s && !busy, "R1", "miss without fill", 64'(req_wr - s), 64'd0);
        fetch_filling = 1'b1;
        @(posedge clk); #1;
        miss_valid = 1'b1; miss_line = 27'h300; redirect = 1'b1;
        @(posedge clk); #1;
        miss_valid = 1'b0; redirect = 1'b0;
        repeat (4) @(negedge clk);
        chk(req_wr == s && !busy, "R1", "miss with redirect", 64'(req_wr - s), 64'd0);

        // R9: redirect before any grant cancels the whole burst
        @(posedge clk); #1;
        breq_grant = 1'b0;
        tb_base = 32'h0000_7000;
        pulse_miss(32'h0000_7000);
        repeat (2) @(negedge clk);
        chk(breq_valid && breq_addr == 32'h0000_7000, "R2", "held demand request",
            64'(breq_addr), 64'h7000);
        @(posedge clk); #1;
        redirect = 1'b1;
        @(posedge clk); #1;
        redirect = 1'b0;
        breq_grant = 1'b1;
        repeat (5) @(negedge clk);
        chk(req_wr == s, "R9", "cancelled before issue", 64'(req_wr - s), 64'd0);
        chk(!busy, "R9", "idle after cancel", 64'(busy), 64'd0);

        // R9: redirect against the second request; first still filled
        s = req_wr; wr0 = n_wr; fw0 = n_fwd;
        tb_base = 32'h0000_8000;
        dq[dq_wr & 15] = 32'h0000_8000;
        dq_wr++;
        pulse_miss(32'h0000_8000);
        @(posedge clk); #1;
        redirect = 1'b1;
        @(posedge clk); #1;
        redirect = 1'b0;
        wait_idle();
        chk(req_wr - s == 1, "R9", "requests before redirect", 64'(req_wr - s), 64'd1);
        chk(req_log[s & 63] == 32'h0000_8000, "R9", "surviving request", 64'(req_log[s & 63]), 64'h8000);
        chk(n_wr - wr0 == 4, "R9", "in-flight line written", 64'(n_wr - wr0), 64'd4);
        chk(n_fwd - fw0 == 4, "R8", "in-flight demand forwarded", 64'(n_fwd - fw0), 64'd4);

        // R6 R11: saturate eight outstanding, then drain with a burst waiting
        s = req_wr; wr0 = n_wr;
        @(posedge clk); #1;
        resp_en = 1'b0;
        tb_base = 32'h0000_9000;
        dq[dq_wr & 15] = 32'h0000_9000; dq_wr++;
        pulse_miss(32'h0000_9000);
        repeat (6) @(negedge clk);
        tb_base = 32'h0000_A000;
        dq[dq_wr & 15] = 32'h0000_A000; dq_wr++;
        pulse_miss(32'h0000_A000);
        repeat (6) @(negedge clk);
        chk(req_wr - s == 8, "R6", "issued without data", 64'(req_wr - s), 64'd8);
        chk(busy, "R11", "busy with lines outstanding", 64'(busy), 64'd1);
        tb_base = 32'h0000_B000;
        dq[dq_wr & 15] = 32'h0000_B000; dq_wr++;
        pulse_miss(32'h0000_B000);
        repeat (6) @(negedge clk);
        chk(req_wr - s == 8 && !breq_valid, "R6", "stalled at limit", 64'(req_wr - s), 64'd8);
        @(posedge clk); #1;
        resp_en = 1'b1;
        wait_idle();
        chk(req_wr - s == 12, "R6", "requests after drain", 64'(req_wr - s), 64'd12);
        chk(req_log[(s + 8) & 63] == 32'h0000_B000, "R6", "resumed burst start",
            64'(req_log[(s + 8) & 63]), 64'hB000);
        chk(n_wr - wr0 == 48, "R7", "writes after drain", 64'(n_wr - wr0), 64'd48);
        chk(!busy, "R11", "busy low after drain", 64'(busy), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule